// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is a 16-bit up-counter that serves as a general timer or as a counter of external events. A 4-bit control field selects one of four counting arrangements, the count source and a gating option. In timer mode the block counts one-cycle pulses of a shared, already prescaled timer tick. In counter mode it counts falling edges on an external event pin. It samples that pin once every two oscillator cycles through a small two-state edge machine.

Software writes and reads the count, a 16-bit reload value and the control field through one register port. Two run inputs start and stop the counting. A gate pin can stop the counting from outside. Two sticky overflow flags act as interrupt requests. The second flag belongs to a neighbouring timer and is set only in the split-byte mode. The prescaler that makes the tick lies outside this block. It divides the oscillator by 4, 16 or 64, with one rate shared by all timers.

The event edge machine has two states. In `ST_WAIT_HIGH` it waits for a high sample. The `ARM` transition, taken on a high sample, moves it to `ST_ARMED`. In `ST_ARMED` a low sample takes the `FIRE` transition back to `ST_WAIT_HIGH` and sends one count pulse. Reset enters `ST_WAIT_HIGH`, so an event pin that is low at reset is not counted.

Top module: `mm_timer`

## Requirements
- R1: After reset the count, the reload value, the control field (read at `rd_sel`=2) and both flags (read at `rd_sel`=3, bit0 `ovf`, bit1 `ovf_hi`) all read zero.
- R2: In mode 00 (control bits [1:0]), each enabled count step adds one. A step taken from FFFFh loads the reload value (written with `wr_sel`=1) and sets `ovf` in that same cycle.
- R3: In mode 01, a step from FFFFh gives 0000h and sets `ovf`. Nothing is reloaded.
- R4: In mode 10 only the low byte counts. A step from FFh copies the high byte into the low byte and sets `ovf`. The high byte never changes.
- R5: In mode 11 (with `SPLIT_EN`=1) the low byte counts under `run`, the gate and the selected source, and sets `ovf` when it wraps from FFh. The high byte counts `tick` pulses whenever `hi_run` is 1, and sets `ovf_hi` when it wraps from FFh.
- R6: With control bit 2 at 0, each one-cycle `tick` pulse is one count step. With control bit 2 at 1, `tick` is ignored and falling edges of `evt_pin` are the steps.
- R7: `evt_pin` is sampled on every second clock. A high-to-low change, with each level held for at least two clocks, gives exactly one step. The step shows in the count within three clock edges of the change. A rising edge gives no step.
- R8: With control bit 3 at 1, steps count only while `gate_pin` is high. With control bit 3 at 0, `gate_pin` has no effect.
- R9: While `run` is 0, the count does not change except by a software write.
- R10: A flag stays set until its clear input is pulsed. If the clear and a new overflow fall in the same cycle, the flag stays set.
- R11: A count write (`wr_sel`=0) takes priority over a step in the same cycle. The written value is loaded and no overflow is raised. The count can be read at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 2 | write target: 0 count, 1 reload, 2 control |
| wr_data | input | 16 | write data |
| rd_sel | input | 2 | read source: 0 count, 1 reload, 2 control, 3 flags |
| rd_data | output | 16 | read data (combinational) |
| run | input | 1 | run enable for the main counter / low byte |
| hi_run | input | 1 | run enable for the high byte in mode 11 |
| gate_pin | input | 1 | external gate pin |
| evt_pin | input | 1 | external event pin |
| tick | input | 1 | one-cycle pulse of the prescaled timer clock |
| ovf_clr | input | 1 | clears `ovf` |
| ovf_hi_clr | input | 1 | clears `ovf_hi` |
| ovf | output | 1 | overflow flag of the main counter |
| ovf_hi | output | 1 | overflow flag of the mode 11 high byte |

## Verification
A `tick` or a count write changes the count at the next clock edge. The flags are set at that same edge. The bench drives every input just after a falling clock edge and reads the outputs one full cycle later, on the next falling edge. An event-pin change needs up to three rising edges: one to reach the sample phase, one for the `FIRE` pulse and one for the count. The bench waits three rising edges, then reads on the falling edge that follows. Every level it applies is held for at least four clocks.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MODE_RELOAD16 = 2'b00,
        MODE_FREE16   = 2'b01,
        MODE_RELOAD8  = 2'b10,
        MODE_SPLIT8   = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        ST_WAIT_HIGH = 1'b0,
        ST_ARMED     = 1'b1
    } edge_state_e;

    typedef struct packed {
        logic      gate;
        logic      ext_src;
        cnt_mode_e mode;
    } ctrl_t;

    localparam int CTRL_W = 4;

endpackage

// File: rtl/mmt_evt_edge.sv
module mmt_evt_edge
    import mmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    logic        phase;
    edge_state_e state_q, state_d;
    logic        fall_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_HIGH;
        else        state_q <= state_d;
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        fall_d  = 1'b0;
        if (phase) begin
            unique case (state_q)
                ST_WAIT_HIGH: if (pin)  state_d = ST_ARMED;          // ARM
                ST_ARMED:     if (!pin) begin                        // FIRE
                    state_d = ST_WAIT_HIGH;
                    fall_d  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fall <= 1'b0;
        else        fall <= fall_d;
    end

    // R7: one transition yields a single pulse
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/mmt_flag.sv
module mmt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

endmodule

// File: rtl/mmt_count_core.sv
module mmt_count_core
    import mmt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SPLIT_EN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic             en_lo,
    input  logic             en_hi,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_lo,
    output logic             wrap_hi
);

    localparam int         HALF     = CNT_W / 2;
    localparam logic [CNT_W-1:0] ALL_F = {CNT_W{1'b1}};
    localparam logic [HALF-1:0]  HALF_F = {HALF{1'b1}};

    logic [CNT_W-1:0] nxt;
    logic [HALF-1:0]  lo, hi;
    logic             wl, wh;

    assign lo = cnt[HALF-1:0];
    assign hi = cnt[CNT_W-1:HALF];

    generate
        if (SPLIT_EN != 0) begin : g_split
            always_comb begin
                nxt = cnt;
                wl  = 1'b0;
                wh  = 1'b0;
                unique case (mode)
                    MODE_RELOAD16: if (en_lo) begin
                        if (cnt == ALL_F) begin nxt = reload; wl = 1'b1; end
                        else nxt = cnt + 1'b1;
                    end
                    MODE_FREE16: if (en_lo) begin
                        nxt = cnt + 1'b1;
                        wl  = (cnt == ALL_F);
                    end
                    MODE_RELOAD8: if (en_lo) begin
                        if (lo == HALF_F) begin nxt[HALF-1:0] = hi; wl = 1'b1; end
                        else nxt[HALF-1:0] = lo + 1'b1;
                    end
                    MODE_SPLIT8: begin
                        if (en_lo) begin
                            nxt[HALF-1:0] = lo + 1'b1;
                            wl = (lo == HALF_F);
                        end
                        if (en_hi) begin
                            nxt[CNT_W-1:HALF] = hi + 1'b1;
                            wh = (hi == HALF_F);
                        end
                    end
                endcase
            end
        end else begin : g_nosplit
            always_comb begin
                nxt = cnt;
                wl  = 1'b0;
                wh  = 1'b0;
                unique case (mode)
                    MODE_RELOAD16: if (en_lo) begin
                        if (cnt == ALL_F) begin nxt = reload; wl = 1'b1; end
                        else nxt = cnt + 1'b1;
                    end
                    MODE_FREE16: if (en_lo) begin
                        nxt = cnt + 1'b1;
                        wl  = (cnt == ALL_F);
                    end
                    MODE_RELOAD8: if (en_lo) begin
                        if (lo == HALF_F) begin nxt[HALF-1:0] = hi; wl = 1'b1; end
                        else nxt[HALF-1:0] = lo + 1'b1;
                    end
                    MODE_SPLIT8: begin
                        nxt = cnt;
                    end
                endcase
            end
        end
    endgenerate

    assign wrap_lo = wl & ~cnt_wr;
    assign wrap_hi = wh & ~cnt_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= wr_data;
        else             cnt <= nxt;
    end

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD16 && en_lo && !cnt_wr && cnt == ALL_F)
        |=> cnt == $past(reload));

    p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREE16 && en_lo && !cnt_wr && cnt == ALL_F)
        |=> cnt == '0);

    p_hi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD8 && !cnt_wr)
        |=> cnt[CNT_W-1:HALF] == $past(cnt[CNT_W-1:HALF]));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(wr_data));

endmodule

// File: rtl/mm_timer.sv
module mm_timer
    import mmt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SPLIT_EN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             run,
    input  logic             hi_run,
    input  logic             gate_pin,
    input  logic             evt_pin,
    input  logic             tick,
    input  logic             ovf_clr,
    input  logic             ovf_hi_clr,
    output logic             ovf,
    output logic             ovf_hi
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             evt_fall, step, en_lo, en_hi, cnt_wr;
    logic             wrap_lo, wrap_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            reload <= '0;
        end else if (wr_en) begin
            if (wr_sel == 2'd1) reload <= wr_data;
            if (wr_sel == 2'd2) ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    assign cnt_wr = wr_en && (wr_sel == 2'd0);

    mmt_evt_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (evt_pin),
        .fall (evt_fall)
    );

    assign step  = ctrl.ext_src ? evt_fall : tick;
    assign en_lo = run && (!ctrl.gate || gate_pin) && step;
    assign en_hi = hi_run && tick;

    mmt_count_core #(.CNT_W(CNT_W), .SPLIT_EN(SPLIT_EN)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (ctrl.mode),
        .en_lo  (en_lo),
        .en_hi  (en_hi),
        .cnt_wr (cnt_wr),
        .wr_data(wr_data),
        .reload (reload),
        .cnt    (cnt),
        .wrap_lo(wrap_lo),
        .wrap_hi(wrap_hi)
    );

    mmt_flag u_flag_lo (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (wrap_lo),
        .clr  (ovf_clr),
        .q    (ovf)
    );

    mmt_flag u_flag_hi (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (wrap_hi),
        .clr  (ovf_hi_clr),
        .q    (ovf_hi)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            2'd0: rd_data = cnt;
            2'd1: rd_data = reload;
            2'd2: rd_data[CTRL_W-1:0] = ctrl;
            2'd3: rd_data[1:0] = {ovf_hi, ovf};
        endcase
    end

    p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && ctrl.mode != MODE_SPLIT8 && !cnt_wr) |=> $stable(cnt));

    p_gate_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.gate && !gate_pin && ctrl.mode != MODE_SPLIT8 && !cnt_wr)
        |=> $stable(cnt));

endmodule

// File: tb/mm_timer_test.sv
`timescale 1ns/1ps
module mm_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        run = 1'b0, hi_run = 1'b0, gate_pin = 1'b0, evt_pin = 1'b1;
    logic        tick = 1'b0, ovf_clr = 1'b0, ovf_hi_clr = 1'b0;
    logic        ovf, ovf_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mm_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .run(run), .hi_run(hi_run), .gate_pin(gate_pin), .evt_pin(evt_pin),
        .tick(tick), .ovf_clr(ovf_clr), .ovf_hi_clr(ovf_hi_clr),
        .ovf(ovf), .ovf_hi(ovf_hi)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clear_flags();
        ovf_clr = 1'b1; ovf_hi_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0; ovf_hi_clr = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); check("R1 count", v, 16'h0000);
        rd(2'd1, v); check("R1 reload", v, 16'h0000);
        rd(2'd2, v); check("R1 control", v, 16'h0000);
        rd(2'd3, v); check("R1 flags", v, 16'h0000);
    endtask

    task automatic t_mode00();
        logic [15:0] v;
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h1234);
        wr(2'd0, 16'hFFFE);
        run = 1'b1;
        ticks(1);
        rd(2'd0, v); check("R2 step", v, 16'hFFFF);
        check("R2 no flag yet", {15'd0, ovf}, 16'h0000);
        ticks(1);
        rd(2'd0, v); check("R2 reload", v, 16'h1234);
        check("R2 flag", {15'd0, ovf}, 16'h0001);
        @(negedge clk);
        check("R10 flag held", {15'd0, ovf}, 16'h0001);
        clear_flags();
        check("R10 cleared", {15'd0, ovf}, 16'h0000);
    endtask

    task automatic t_mode01();
        logic [15:0] v;
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'hFFFF);
        ticks(1);
        rd(2'd0, v); check("R3 wrap", v, 16'h0000);
        check("R3 flag", {15'd0, ovf}, 16'h0001);
        wr(2'd0, 16'hFFFF);
        ovf_clr = 1'b1; tick = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0; tick = 1'b0;
        check("R10 set wins", {15'd0, ovf}, 16'h0001);
        clear_flags();
    endtask

    task automatic t_mode10();
        logic [15:0] v;
        wr(2'd2, 16'h0002);
        wr(2'd0, 16'h40FE);
        ticks(1);
        rd(2'd0, v); check("R4 step", v, 16'h40FF);
        ticks(1);
        rd(2'd0, v); check("R4 reload low", v, 16'h4040);
        check("R4 flag", {15'd0, ovf}, 16'h0001);
        clear_flags();
    endtask

    task automatic t_mode11();
        logic [15:0] v;
        wr(2'd2, 16'h0003);
        wr(2'd0, 16'h10FF);
        hi_run = 1'b0; run = 1'b1;
        ticks(1);
        rd(2'd0, v); check("R5 low wraps, high held", v, 16'h1000);
        check("R5 ovf", {14'd0, ovf_hi, ovf}, 16'h0001);
        clear_flags();
        wr(2'd0, 16'hFF05);
        run = 1'b0; hi_run = 1'b1;
        ticks(1);
        rd(2'd0, v); check("R5 high wraps, low held", v, 16'h0005);
        check("R5 ovf_hi", {14'd0, ovf_hi, ovf}, 16'h0002);
        hi_run = 1'b0; run = 1'b1;
        clear_flags();
    endtask

    task automatic t_gate_run();
        logic [15:0] v;
        wr(2'd2, 16'h0009);            // gate=1, mode 01
        wr(2'd0, 16'h0010);
        gate_pin = 1'b0;
        ticks(2);
        rd(2'd0, v); check("R8 gate low blocks", v, 16'h0010);
        gate_pin = 1'b1;
        ticks(1);
        rd(2'd0, v); check("R8 gate high counts", v, 16'h0011);
        wr(2'd2, 16'h0001);            // gate=0
        gate_pin = 1'b0;
        ticks(1);
        rd(2'd0, v); check("R8 gate ignored", v, 16'h0012);
        run = 1'b0;
        ticks(3);
        rd(2'd0, v); check("R9 stopped", v, 16'h0012);
        run = 1'b1;
    endtask

    task automatic t_counter();
        logic [15:0] v;
        wr(2'd2, 16'h0005);            // external source, mode 01
        wr(2'd0, 16'h0000);
        evt_pin = 1'b1;
        repeat (4) @(negedge clk);
        ticks(3);
        rd(2'd0, v); check("R6 tick ignored", v, 16'h0000);
        evt_pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); check("R7 fall latency", v, 16'h0001);
        repeat (4) @(negedge clk);
        evt_pin = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, v); check("R7 rise ignored", v, 16'h0001);
        for (int i = 0; i < 3; i++) begin
            evt_pin = 1'b0; repeat (4) @(negedge clk);
            evt_pin = 1'b1; repeat (4) @(negedge clk);
        end
        rd(2'd0, v); check("R7 three edges", v, 16'h0004);
    endtask

    task automatic t_write_prio();
        logic [15:0] v;
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'hFFFF);
        tick = 1'b1;
        wr(2'd0, 16'h0100);
        tick = 1'b0;
        rd(2'd0, v); check("R11 write wins", v, 16'h0100);
        check("R11 no overflow", {15'd0, ovf}, 16'h0000);
        ticks(1);
        rd(2'd0, v); check("R11 read while running", v, 16'h0101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode00();
        t_mode01();
        t_mode10();
        t_mode11();
        t_gate_run();
        t_counter();
        t_write_prio();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule